// File: doc/BRIEF.md
# DRAM Bank Open-Row Tracker

This block sits between a request queue and a DRAM command bus. It keeps, for every bank, a record of whether a row is open and which row it is. It turns each incoming access (bank, row, column, read or write) into the command sequence that access needs. A hit on the open row goes straight to a read or write. A request to an idle bank first activates the row and waits the activate-to-column delay. A request to a different row first closes the open row with a precharge, waits the row precharge time, and then activates. Only the addressed bank is held up by these waits.

A single request port carries one access at a time. The requester holds `req_valid_i` and the request fields steady until `req_ready_o` goes high. `req_ready_o` is high in the cycle the column command for that request goes out. A request may be withdrawn or replaced before it is accepted. When that happens, a bank that has started a precharge or activate finishes it and then rests. This lets the requester serve another bank while one bank is precharging.

A refresh scheduler raises `refresh_req_i` to have every open bank precharged. It waits for `all_idle_o`, then holds `refresh_busy_i` while the refresh runs. No activate is issued while either of those two inputs is high. The row precharge time is given in picoseconds and converted to clock cycles from the clock period. The activate-to-column delay is given directly in cycles. The default build has 8 banks.

Top module: `bank_row_tracker`

## Requirements
- R1: After reset no command is issued, `req_ready_o` is low and `all_idle_o` is high.
- R2: A request to a bank with no open row issues an activate to that bank, carrying `req_row_i`, in the same cycle the request is presented. The matching read or write, carrying `req_col_i`, follows exactly T_RCD cycles later, with `req_ready_o` high in that cycle only.
- R3: A request whose row equals the bank's open row issues the column command in the same cycle, with no activate and with `req_ready_o` high. `req_write_i` = 1 selects a write; `req_write_i` = 0 selects a read.
- R4: A request to a bank whose open row differs from `req_row_i` issues a precharge to that bank first. The activate of the new row follows exactly T_RP cycles later, where T_RP = ceil(T_RP_PS / CLK_PS). The column command follows T_RCD cycles after the activate.
- R5: While one bank is precharging, a request to an open row of another bank is served in the same cycle.
- R6: A bank never receives an activate while it has an open row. A request withdrawn before acceptance causes no further activate for the bank it addressed.
- R7: When several banks need a command in the same cycle, the lowest-numbered bank is served first.
- R8: While `refresh_req_i` is high, every open bank is precharged and no activate is issued. `all_idle_o` rises once every bank has finished its precharge. No activate is issued while `refresh_busy_i` is high, and a held request issues its activate in the first cycle after `refresh_busy_i` falls.
- R9: At most one of `cmd_act_o`, `cmd_rd_o`, `cmd_wr_o` and `cmd_pre_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | An access request is present |
| req_bank_i | input | BANK_W | Bank addressed by the request |
| req_row_i | input | ROW_W | Row addressed by the request |
| req_col_i | input | COL_W | Column addressed by the request |
| req_write_i | input | 1 | 1 for a write, 0 for a read |
| req_ready_o | output | 1 | Request accepted (its column command issues this cycle) |
| refresh_req_i | input | 1 | Close all banks for a refresh |
| refresh_busy_i | input | 1 | Refresh in progress; activates are blocked |
| all_idle_o | output | 1 | Every bank is idle with no row open |
| cmd_act_o | output | 1 | Activate command |
| cmd_rd_o | output | 1 | Read command |
| cmd_wr_o | output | 1 | Write command |
| cmd_pre_o | output | 1 | Precharge command |
| cmd_bank_o | output | BANK_W | Bank of the issued command |
| cmd_row_o | output | ROW_W | Row of an activate, or the open row for other commands |
| cmd_col_o | output | COL_W | Column of a read or write |

## Verification
The hardest situation to reach is a second bank being served while another bank sits in its precharge wait. The single request port would otherwise keep the requester parked on the blocked bank. The bench first opens two banks. It then sends a row miss to one bank and, in the cycle after the precharge appears, swaps the request to the other bank's open row. This shows the hit served during the wait, and it also shows that the abandoned bank stays quiet afterwards. The refresh scenario is set up the same way, with two banks open at once, so that the priority order of the precharges and the exact cycle at which `all_idle_o` rises can both be observed.

// File: rtl/brt_pkg.sv
package brt_pkg;
  typedef enum logic [1:0] {
    BS_IDLE, BS_ACTIVE, BS_PRECHARGING, BS_ACTIVATING
  } bank_state_e;

  typedef enum logic [2:0] {
    BC_NONE, BC_ACT, BC_RD, BC_WR, BC_PRE
  } bank_cmd_e;
endpackage

// File: rtl/brt_bank_fsm.sv
module brt_bank_fsm
  import brt_pkg::*;
#(
  parameter int ROW_W = 14,
  parameter int T_RCD = 4,
  parameter int T_RP  = 5,
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             want_i,
  input  logic [ROW_W-1:0] want_row_i,
  input  logic             want_wr_i,
  input  logic             close_all_i,
  input  logic             block_act_i,
  input  logic             grant_i,
  output bank_cmd_e        cmd_o,
  output bank_state_e      state_o,
  output logic [ROW_W-1:0] open_row_o
);
  localparam logic [CNT_W-1:0] RCD_LD = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] RP_LD  = CNT_W'(T_RP - 1);

  bank_state_e      state_q;
  logic [ROW_W-1:0] row_q;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    cmd_o = BC_NONE;
    case (state_q)
      BS_IDLE:
        if (want_i && !block_act_i) cmd_o = BC_ACT;
      BS_ACTIVE:
        if (close_all_i)                    cmd_o = BC_PRE;
        else if (want_i && row_q != want_row_i) cmd_o = BC_PRE;
        else if (want_i)                    cmd_o = want_wr_i ? BC_WR : BC_RD;
      default: cmd_o = BC_NONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= BS_IDLE;
      row_q   <= '0;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        BS_IDLE:
          if (grant_i && cmd_o == BC_ACT) begin
            row_q <= want_row_i;
            if (T_RCD > 1) begin
              state_q <= BS_ACTIVATING;
              cnt_q   <= RCD_LD;
            end else begin
              state_q <= BS_ACTIVE;
            end
          end
        BS_ACTIVE:
          if (grant_i && cmd_o == BC_PRE) begin
            if (T_RP > 1) begin
              state_q <= BS_PRECHARGING;
              cnt_q   <= RP_LD;
            end else begin
              state_q <= BS_IDLE;
            end
          end
        BS_PRECHARGING:
          if (cnt_q <= 1) state_q <= BS_IDLE;
          else            cnt_q   <= cnt_q - 1'b1;
        BS_ACTIVATING:
          if (cnt_q <= 1) state_q <= BS_ACTIVE;
          else            cnt_q   <= cnt_q - 1'b1;
        default: state_q <= BS_IDLE;
      endcase
    end
  end

  assign state_o    = state_q;
  assign open_row_o = row_q;
endmodule

// File: rtl/brt_prio_arb.sv
module brt_prio_arb #(
  parameter int N = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     gnt_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    any_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !any_o) begin
        any_o    = 1'b1;
        gnt_o[i] = 1'b1;
        idx_o    = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/bank_row_tracker.sv
module bank_row_tracker
  import brt_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  parameter int COL_W     = 10,
  parameter int CLK_PS    = 2500,
  parameter int T_RP_PS   = 12000,
  parameter int T_RCD     = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int T_RP     = (T_RP_PS + CLK_PS - 1) / CLK_PS,
  localparam int T_MAX    = (T_RP > T_RCD) ? T_RP : T_RCD,
  localparam int CNT_W    = $clog2(T_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic              req_write_i,
  output logic              req_ready_o,
  input  logic              refresh_req_i,
  input  logic              refresh_busy_i,
  output logic              all_idle_o,
  output logic              cmd_act_o,
  output logic              cmd_rd_o,
  output logic              cmd_wr_o,
  output logic              cmd_pre_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [ROW_W-1:0]  cmd_row_o,
  output logic [COL_W-1:0]  cmd_col_o
);
  logic [NUM_BANKS-1:0] bank_req, bank_idle, gnt;
  logic [BANK_W-1:0]    win;
  logic                 any;
  logic                 block_act;
  bank_cmd_e            bank_cmd [NUM_BANKS];
  bank_state_e          bank_st  [NUM_BANKS];
  logic [ROW_W-1:0]     bank_row [NUM_BANKS];
  bank_cmd_e            sel;

  assign block_act = refresh_req_i | refresh_busy_i;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic want;
    assign want = req_valid_i && (req_bank_i == BANK_W'(b));

    brt_bank_fsm #(
      .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RP(T_RP), .CNT_W(CNT_W)
    ) u_fsm (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .want_i      (want),
      .want_row_i  (req_row_i),
      .want_wr_i   (req_write_i),
      .close_all_i (refresh_req_i),
      .block_act_i (block_act),
      .grant_i     (gnt[b]),
      .cmd_o       (bank_cmd[b]),
      .state_o     (bank_st[b]),
      .open_row_o  (bank_row[b])
    );

    assign bank_req[b]  = bank_cmd[b] != BC_NONE;
    assign bank_idle[b] = bank_st[b] == BS_IDLE;
  end

  brt_prio_arb #(.N(NUM_BANKS)) u_arb (
    .req_i (bank_req),
    .gnt_o (gnt),
    .idx_o (win),
    .any_o (any)
  );

  assign sel         = any ? bank_cmd[win] : BC_NONE;
  assign cmd_act_o   = sel == BC_ACT;
  assign cmd_rd_o    = sel == BC_RD;
  assign cmd_wr_o    = sel == BC_WR;
  assign cmd_pre_o   = sel == BC_PRE;
  assign cmd_bank_o  = win;
  assign cmd_row_o   = cmd_act_o ? req_row_i : bank_row[win];
  assign cmd_col_o   = req_col_i;
  assign req_ready_o = cmd_rd_o | cmd_wr_o;
  assign all_idle_o  = &bank_idle;
endmodule

// File: rtl/brt_checker.sv
module brt_checker #(
  parameter int NUM_BANKS = 8,
  parameter int T_RP      = 5,
  parameter int T_RCD     = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              refresh_busy_i,
  input logic              all_idle_o,
  input logic              cmd_act_o,
  input logic              cmd_rd_o,
  input logic              cmd_wr_o,
  input logic              cmd_pre_o,
  input logic [BANK_W-1:0] cmd_bank_o
);
  int unsigned          since_pre [NUM_BANKS];
  int unsigned          since_act [NUM_BANKS];
  logic [NUM_BANKS-1:0] open_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
        since_pre[b] <= T_RP;
        since_act[b] <= 0;
      end
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (cmd_pre_o && cmd_bank_o == BANK_W'(b)) begin
          since_pre[b] <= 1;
          open_q[b]    <= 1'b0;
        end else if (since_pre[b] < T_RP) begin
          since_pre[b] <= since_pre[b] + 1;
        end
        if (cmd_act_o && cmd_bank_o == BANK_W'(b)) begin
          since_act[b] <= 1;
          open_q[b]    <= 1'b1;
        end else if (since_act[b] < T_RCD) begin
          since_act[b] <= since_act[b] + 1;
        end
      end
    end
  end

  // R9
  one_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cmd_act_o, cmd_rd_o, cmd_wr_o, cmd_pre_o}));

  // R4
  trp_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_act_o |-> since_pre[cmd_bank_o] >= T_RP);

  // R2
  trcd_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_rd_o || cmd_wr_o) |-> (open_q[cmd_bank_o] && since_act[cmd_bank_o] >= T_RCD));

  // R6
  single_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_act_o |-> !open_q[cmd_bank_o]);

  // R8
  refresh_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_busy_i |-> !cmd_act_o);

  // R8
  idle_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_idle_o |-> open_q == '0);
endmodule

bind bank_row_tracker brt_checker #(
  .NUM_BANKS(NUM_BANKS), .T_RP(T_RP), .T_RCD(T_RCD)
) u_brt_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .refresh_busy_i (refresh_busy_i),
  .all_idle_o     (all_idle_o),
  .cmd_act_o      (cmd_act_o),
  .cmd_rd_o       (cmd_rd_o),
  .cmd_wr_o       (cmd_wr_o),
  .cmd_pre_o      (cmd_pre_o),
  .cmd_bank_o     (cmd_bank_o)
);

// File: tb/bank_row_tracker_test.sv
module bank_row_tracker_test;
  localparam int CLK_PERIOD = 10;
  localparam int NB   = 8;
  localparam int RW   = 14;
  localparam int CW   = 10;
  localparam int BW   = 3;
  localparam int CPS  = 2500;
  localparam int RPPS = 12000;
  localparam int TRCD = 4;
  localparam int TRP  = (RPPS + CPS - 1) / CPS;

  localparam logic [3:0] K_NONE = 4'b0000;
  localparam logic [3:0] K_ACT  = 4'b1000;
  localparam logic [3:0] K_RD   = 4'b0100;
  localparam logic [3:0] K_WR   = 4'b0010;
  localparam logic [3:0] K_PRE  = 4'b0001;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [BW-1:0] req_bank_i = '0;
  logic [RW-1:0] req_row_i = '0;
  logic [CW-1:0] req_col_i = '0;
  logic refresh_req_i = 1'b0, refresh_busy_i = 1'b0;
  logic req_ready_o, all_idle_o, cmd_act_o, cmd_rd_o, cmd_wr_o, cmd_pre_o;
  logic [BW-1:0] cmd_bank_o;
  logic [RW-1:0] cmd_row_o;
  logic [CW-1:0] cmd_col_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bank_row_tracker #(
    .NUM_BANKS(NB), .ROW_W(RW), .COL_W(CW), .CLK_PS(CPS), .T_RP_PS(RPPS), .T_RCD(TRCD)
  ) uut (.*);

  task automatic next;
    @(negedge clk_i);
  endtask

  task automatic settle;
    #1;
  endtask

  task automatic drive(input logic v, input int bank, input int row, input int col, input logic wr);
    req_valid_i = v;
    req_bank_i  = BW'(bank);
    req_row_i   = RW'(row);
    req_col_i   = CW'(col);
    req_write_i = wr;
  endtask

  task automatic expect_cmd(input string tag, input logic [3:0] k, input int bank, input int val, input logic rdy);
    logic [3:0] got;
    bit bad;
    got = {cmd_act_o, cmd_rd_o, cmd_wr_o, cmd_pre_o};
    bad = (got !== k) || (req_ready_o !== rdy);
    if (k != K_NONE && cmd_bank_o !== BW'(bank)) bad = 1;
    if (k == K_ACT && cmd_row_o !== RW'(val)) bad = 1;
    if ((k == K_RD || k == K_WR) && cmd_col_o !== CW'(val)) bad = 1;
    n_chk++;
    if (bad) begin
      n_fail++;
      $display("FAIL %s: cmd=%b bank=%0d row=%0h col=%0h rdy=%b, expected cmd=%b bank=%0d val=%0h rdy=%b",
               tag, got, cmd_bank_o, cmd_row_o, cmd_col_o, req_ready_o, k, bank, val, rdy);
    end
  endtask

  task automatic expect_idle_flag(input string tag, input logic exp);
    n_chk++;
    if (all_idle_o !== exp) begin
      n_fail++;
      $display("FAIL %s: all_idle=%b, expected %b", tag, all_idle_o, exp);
    end
  endtask

  // R2: access to a bank with no open row
  task automatic access_new(input string tag, input int bank, input int row, input int col, input logic wr);
    next; drive(1, bank, row, col, wr); settle;
    expect_cmd({tag, " R2 act"}, K_ACT, bank, row, 0);
    for (int k = 1; k < TRCD; k++) begin
      next; settle;
      expect_cmd({tag, " R2 trcd wait"}, K_NONE, 0, 0, 0);
    end
    next; settle;
    expect_cmd({tag, " R2 column"}, wr ? K_WR : K_RD, bank, col, 1);
    next; drive(0, 0, 0, 0, 0); settle;
    expect_cmd({tag, " R2 released"}, K_NONE, 0, 0, 0);
  endtask

  task automatic t_reset;
    repeat (2) next;
    rst_ni = 1'b1;
    settle;
    expect_cmd("R1 reset", K_NONE, 0, 0, 0);
    expect_idle_flag("R1 reset idle", 1);
  endtask

  task automatic t_hit;
    access_new("bank0 first", 0, 'h12, 5, 0);
    next; drive(1, 0, 'h12, 7, 1); settle;
    expect_cmd("R3 hit write", K_WR, 0, 7, 1);
    next; drive(1, 0, 'h12, 9, 0); settle;
    expect_cmd("R3 hit read", K_RD, 0, 9, 1);
    next; drive(0, 0, 0, 0, 0);
  endtask

  task automatic t_miss;
    next; drive(1, 0, 'h34, 1, 0); settle;
    expect_cmd("R4 pre", K_PRE, 0, 0, 0);
    for (int k = 1; k < TRP; k++) begin
      next; settle;
      expect_cmd("R4 trp wait", K_NONE, 0, 0, 0);
    end
    next; settle;
    expect_cmd("R4 act", K_ACT, 0, 'h34, 0);
    for (int k = 1; k < TRCD; k++) begin
      next; settle;
      expect_cmd("R4 trcd wait", K_NONE, 0, 0, 0);
    end
    next; settle;
    expect_cmd("R4 column", K_RD, 0, 1, 1);
    next; drive(0, 0, 0, 0, 0);
  endtask

  task automatic t_other_bank;
    access_new("bank2 open", 2, 'h55, 2, 0);
    next; drive(1, 0, 'h99, 4, 1); settle;
    expect_cmd("R5 pre bank0", K_PRE, 0, 0, 0);
    next; drive(1, 2, 'h55, 3, 0); settle;
    expect_cmd("R5 bank2 hit during precharge", K_RD, 2, 3, 1);
    for (int k = 0; k < 8; k++) begin
      next; drive(0, 0, 0, 0, 0); settle;
      expect_cmd("R6 withdrawn bank stays quiet", K_NONE, 0, 0, 0);
    end
    next; drive(1, 0, 'h99, 4, 1); settle;
    expect_cmd("R6 act after withdrawal", K_ACT, 0, 'h99, 0);
    for (int k = 1; k < TRCD; k++) begin
      next; settle;
      expect_cmd("R6 trcd wait", K_NONE, 0, 0, 0);
    end
    next; settle;
    expect_cmd("R3 write after activate", K_WR, 0, 4, 1);
    next; drive(0, 0, 0, 0, 0);
  endtask

  task automatic t_refresh;
    next; refresh_req_i = 1'b1; settle;
    expect_cmd("R7 lowest bank first", K_PRE, 0, 0, 0);
    next; settle;
    expect_cmd("R7 second bank next", K_PRE, 2, 0, 0);
    for (int k = 2; k <= TRP; k++) begin
      next; settle;
      expect_cmd("R8 draining", K_NONE, 0, 0, 0);
      expect_idle_flag("R8 not yet idle", 0);
    end
    next; settle;
    expect_idle_flag("R8 all idle", 1);
    next; refresh_req_i = 1'b0; refresh_busy_i = 1'b1; drive(1, 3, 7, 6, 0); settle;
    for (int k = 0; k < 5; k++) begin
      expect_cmd("R8 no act during refresh", K_NONE, 0, 0, 0);
      next; settle;
    end
    refresh_busy_i = 1'b0; settle;
    expect_cmd("R8 act after refresh", K_ACT, 3, 7, 0);
    for (int k = 1; k < TRCD; k++) begin
      next; settle;
      expect_cmd("R8 trcd wait", K_NONE, 0, 0, 0);
    end
    next; settle;
    expect_cmd("R8 column after refresh", K_RD, 3, 6, 1);
    next; drive(0, 0, 0, 0, 0);
  endtask

  initial begin
    t_reset;
    t_hit;
    t_miss;
    t_other_bank;
    t_refresh;
    repeat (2) next;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule